// File: doc/BRIEF.md
# Set-Only GPIO Port

An 8-bit general-purpose I/O port controller on a small synchronous register bus. It holds three pieces of state: a direction mask, an output data latch and a pair of synchronizer stages that sample the pads. Each pad is driven from the latch only when its direction bit marks it as an output.

The bus reaches three registers. The output-data register reads and replaces the whole latch. The direction register picks input or output for each pin. The pin/set register reads back the live, synchronized pad levels instead of the latch contents. A write to it can only set latch bits: each one in the written value sets that bit, and each zero leaves the bit alone. Software can therefore raise chosen outputs without a read-modify-write.

A parameter implements fewer than eight bits. The upper positions then read as zero, ignore writes and never drive their pads.

Top module: `gpio_set_port`

## Requirements
- R1: Each implemented pad's `pad_oe` equals its direction bit: 1 makes the pin an output and 0 makes it an input.
- R2: After reset the direction mask and the output latch are all zeros, so every pin is an input. `reg_rdata` is also zero.
- R3: A read at address 2 (pin/set) returns the synchronized pad levels, not the latch. A pad change made before clock edge k shows on `reg_rdata` after edge k+2 while address 2 is held, and not before.
- R4: A write at address 2 sets every implemented latch bit whose written bit is 1.
- R5: During a write at address 2, latch bits whose written bit is 0 keep their value.
- R6: The synchronizer stages reset to ones. With the pads pulled high, the first pin/set read after reset returns ones in every implemented bit.
- R7: Bit positions at or above `IMPL_W` read as 0 at every address, ignore writes, and keep `pad_oe` and `pad_out` at 0.
- R8: A write at address 0 (output data) replaces all implemented latch bits at once. A read at address 0 returns the latch.
- R9: A write at address 1 (direction) loads the direction mask. A read at address 1 returns it.
- R10: A write takes effect on the clock edge where `reg_we` is high. `reg_rdata` is registered and shows the value from before that edge. Address 3 reads as 0, and writes to it change nothing.
- R11: `pad_out` always carries the implemented output-latch bits, whatever the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 pin/set, 3 unused |
| reg_we | input | 1 | Write enable for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| pad_in | input | DATA_W | Levels seen at the pads |
| pad_out | output | DATA_W | Output latch value toward the pads |
| pad_oe | output | DATA_W | Per-pad output enable |

## Verification
The assertions assume that `reg_addr`, `reg_we` and `reg_wdata` are stable around each rising edge and that `pad_in` carries only known levels. They also assume the bus is idle in the cycle that leaves reset, so the state they infer from past writes starts from the reset values. The bench drives every input at the falling edge and holds `reg_we` low throughout reset. It models each pad as a pulled-high line that follows `pad_out` whenever `pad_oe` is set, so the pads never float or carry unknown values.

// File: rtl/gpio_set_pkg.sv
// gpio_set_pkg
// Shared register-select encoding for the set-only GPIO port.
// Assumes a 2-bit register address on the bus.
package gpio_set_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA   = 2'd0,
        ADDR_DIR    = 2'd1,
        ADDR_PINSET = 2'd2,
        ADDR_NONE   = 2'd3
    } gpio_addr_e;

endpackage

// File: rtl/gpio_pad_sync.sv
// gpio_pad_sync
// Two-flop synchronizer for each implemented pad input.
// Assumes pads idle high, so both stages reset to ones.
module gpio_pad_sync #(
    parameter int IMPL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IMPL_W-1:0] pad_i,
    output logic [IMPL_W-1:0] sync_o
);

    genvar b;
    generate
        for (b = 0; b < IMPL_W; b++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Sample the pad into a metastability stage, then a stable stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    stab_q <= 1'b1;
                end else begin
                    meta_q <= pad_i[b];
                    stab_q <= meta_q;
                end
            end

            assign sync_o[b] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
// gpio_port_regs
// Holds the direction mask and the output latch. A data write replaces
// the latch and a pin/set write ORs ones into it.
// Assumes that the write data has already been cut to the implemented width.
module gpio_port_regs
    import gpio_set_pkg::*;
#(
    parameter int IMPL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  gpio_addr_e        wr_sel,
    input  logic [IMPL_W-1:0] wr_data,
    output logic [IMPL_W-1:0] dir_q,
    output logic [IMPL_W-1:0] latch_q
);

    // Load the direction mask on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_en && (wr_sel == ADDR_DIR)) begin
            dir_q <= wr_data;
        end
    end

    // Replace the latch on a data write and set its bits on a pin/set write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                ADDR_DATA:   latch_q <= wr_data;
                ADDR_PINSET: latch_q <= latch_q | wr_data;
                default:     latch_q <= latch_q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
// gpio_read_mux
// Selects the addressed register and registers it onto the read bus.
// Bits at or above IMPL_W and address 3 return zeros.
module gpio_read_mux
    import gpio_set_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IMPL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gpio_addr_e        rd_sel,
    input  logic [IMPL_W-1:0] latch_i,
    input  logic [IMPL_W-1:0] dir_i,
    input  logic [IMPL_W-1:0] pins_i,
    output logic [DATA_W-1:0] rdata_q
);

    logic [IMPL_W-1:0] sel_val;

    // Pick the value of the addressed register.
    always_comb begin
        case (rd_sel)
            ADDR_DATA:   sel_val = latch_i;
            ADDR_DIR:    sel_val = dir_i;
            ADDR_PINSET: sel_val = pins_i;
            default:     sel_val = '0;
        endcase
    end

    // Register the selection, zero-extended to the bus width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= DATA_W'(sel_val);
        end
    end

endmodule

// File: rtl/gpio_set_port.sv
// gpio_set_port
// Top of the GPIO port. It has a data latch, a direction mask and a pin/set
// register that reads synchronized pads and sets latch bits on write.
// Assumes IMPL_W <= DATA_W. Unimplemented bits read 0 and never drive.
module gpio_set_port
    import gpio_set_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IMPL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe
);

    gpio_addr_e        sel;
    logic [IMPL_W-1:0] dir_q;
    logic [IMPL_W-1:0] latch_q;
    logic [IMPL_W-1:0] pins_sync;

    assign sel = gpio_addr_e'(reg_addr);

    gpio_pad_sync #(
        .IMPL_W (IMPL_W)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in[IMPL_W-1:0]),
        .sync_o (pins_sync)
    );

    gpio_port_regs #(
        .IMPL_W (IMPL_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_sel  (sel),
        .wr_data (reg_wdata[IMPL_W-1:0]),
        .dir_q   (dir_q),
        .latch_q (latch_q)
    );

    gpio_read_mux #(
        .DATA_W (DATA_W),
        .IMPL_W (IMPL_W)
    ) rmux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (sel),
        .latch_i (latch_q),
        .dir_i   (dir_q),
        .pins_i  (pins_sync),
        .rdata_q (reg_rdata)
    );

    // Drive each pad from the latch, enabled by its direction bit.
    assign pad_out = DATA_W'(latch_q);
    assign pad_oe  = DATA_W'(dir_q);

endmodule

// File: rtl/gpio_set_port_chk.sv
// gpio_set_port_chk
// Property checker bound to gpio_set_port. It observes only the top ports.
module gpio_set_port_chk
    import gpio_set_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IMPL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] pad_in,
    input logic [DATA_W-1:0] pad_out,
    input logic [DATA_W-1:0] pad_oe
);

    localparam logic [DATA_W-1:0] IMPL_MASK = {DATA_W{1'b1}} >> (DATA_W - IMPL_W);

    logic unused_in;
    assign unused_in = ^pad_in;

    assert_oe_follows_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_DIR) |=> (pad_oe == ($past(reg_wdata) & IMPL_MASK)));

    assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && reg_rdata == '0));

    assert_set_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_PINSET)
        |=> ((pad_out & $past(reg_wdata) & IMPL_MASK) == ($past(reg_wdata) & IMPL_MASK)));

    assert_set_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_PINSET)
        |=> (((pad_out ^ $past(pad_out)) & ~$past(reg_wdata)) == '0));

    assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | reg_rdata) & ~IMPL_MASK) == '0);

    assert_data_replace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_DATA) |=> (pad_out == ($past(reg_wdata) & IMPL_MASK)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we || reg_addr == ADDR_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));

    assert_none_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_NONE) |=> (reg_rdata == '0));

endmodule

bind gpio_set_port gpio_set_port_chk #(
    .DATA_W (DATA_W),
    .IMPL_W (IMPL_W)
) chk_i (.*);

// File: tb/gpio_set_port_tb.sv
// Bench for gpio_set_port: directed corner cases plus seeded random traffic,
// checked against a model of the three registers and pulled-high pads.
module gpio_set_port_tb_top;

    localparam int DW = 8;
    localparam int IW = 6;
    localparam logic [DW-1:0] MASK = 8'h3F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [DW-1:0] pad_in;
    logic [DW-1:0] pad_out;
    logic [DW-1:0] pad_oe;
    logic [DW-1:0] ext = 8'hFF;

    logic [DW-1:0] m_dir = '0;
    logic [DW-1:0] m_lat = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Pads: driven by the port when enabled, else the external (pulled-up) level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_set_port #(
        .DATA_W (DW),
        .IMPL_W (IW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    function automatic logic [DW-1:0] exp_pins(input logic [DW-1:0] d, input logic [DW-1:0] l,
                                               input logic [DW-1:0] e);
        return ((d & l) | (~d & e)) & MASK;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
        case (a)
            2'd0: m_lat = d & MASK;
            2'd1: m_dir = d & MASK;
            2'd2: m_lat = m_lat | (d & MASK);
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_we   = 1'b0;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [DW-1:0] old_dir;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R2 oe after reset", pad_oe, 8'h00);
        check("R2 latch after reset", pad_out, 8'h00);
        check("R2 rdata after reset", reg_rdata, 8'h00);

        // First pin/set read: sync stages reset to ones and pads are pulled high.
        bus_read(2'd2, rd);
        check("R6 pin read after reset", rd, MASK);

        bus_write(2'd1, 8'hFF);
        check("R1 oe follows dir", pad_oe, MASK);
        bus_read(2'd1, rd);
        check("R9 R7 dir read", rd, MASK);

        bus_write(2'd0, 8'hA5);
        check("R8 R11 data write", pad_out, 8'h25);
        bus_read(2'd0, rd);
        check("R8 data read", rd, 8'h25);

        bus_write(2'd2, 8'h5A);
        check("R4 set write ors", pad_out, 8'h3F);
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h00);
        check("R5 zero set write", pad_out, 8'h00);
        bus_write(2'd0, 8'h30);
        bus_write(2'd2, 8'h03);
        check("R4 R5 set keeps ones", pad_out, 8'h33);

        // Inputs: pin view differs from the latch.
        bus_write(2'd1, 8'h00);
        check("R1 all inputs", pad_oe, 8'h00);
        check("R11 latch kept as inputs", pad_out, 8'h33);
        ext = 8'h0C;
        settle();
        bus_read(2'd2, rd);
        check("R3 pins not latch", rd, 8'h0C);

        // Exact latency with address 2 held.
        @(negedge clk);
        ext = 8'h21;
        repeat (2) @(negedge clk);
        check("R3 not yet visible", reg_rdata, 8'h0C);
        @(negedge clk);
        check("R3 visible after third edge", reg_rdata, 8'h21);

        // Upper pads high, but unimplemented bits read zero.
        ext = 8'hFF;
        settle();
        bus_read(2'd2, rd);
        check("R7 pin upper bits zero", rd, MASK);
        bus_write(2'd0, 8'hC0);
        check("R7 upper write ignored", pad_out, 8'h00);

        // Address 3: reads zero, writes do nothing.
        bus_write(2'd1, 8'h0F);
        bus_write(2'd0, 8'h15);
        bus_write(2'd3, 8'hFF);
        check("R10 addr3 write no oe change", pad_oe, 8'h0F);
        check("R10 addr3 write no latch change", pad_out, 8'h15);
        bus_read(2'd3, rd);
        check("R10 addr3 reads zero", rd, 8'h00);

        // A read of the register being written shows the old value.
        old_dir = m_dir;
        @(negedge clk);
        reg_addr  = 2'd1;
        reg_we    = 1'b1;
        reg_wdata = 8'h2A;
        @(negedge clk);
        reg_we = 1'b0;
        m_dir  = 8'h2A;
        check("R10 registered read old", reg_rdata, old_dir);
        @(negedge clk);
        check("R10 registered read new", reg_rdata, 8'h2A);

        // Seeded random traffic.
        for (int it = 0; it < 200; it++) begin
            logic [1:0]    a;
            logic [DW-1:0] d;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            if ((it % 5) == 0) ext = 8'($urandom);
            bus_write(a, d);
            settle();
            check("R1 random oe", pad_oe, m_dir);
            check("R11 R4 R5 random latch", pad_out, m_lat);
            bus_read(2'd0, rd);
            check("R8 random data read", rd, m_lat);
            bus_read(2'd1, rd);
            check("R9 random dir read", rd, m_dir);
            bus_read(2'd2, rd);
            check("R3 random pin read", rd, exp_pins(m_dir, m_lat, ext));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule